// File: doc/BRIEF.md
# Outbound Address Translation Window Table

This block turns a local request address into a link-side bus address. It holds a small set of programmable outbound windows. Each window has a 64-bit local base, a 64-bit bus base, a size mask, an enable bit and a transaction type: configuration, I/O, memory or atomic. For every accepted request, all windows are compared in parallel. The lowest-numbered enabled window that matches supplies the translated address and the type. A request that matches no window comes back flagged as a miss.

Software programs the windows through a flat 32-bit register port. Each access selects a window index and a register. The size is written as an inverted mask, the complement of (size-1). The mask's upper 32 bits sit in their own register, and its lower part shares the control word with the enable bit and the type field.

A configuration-type hit is handled differently. Its output carries a target identifier (bus, device, function) taken from the window's bus-side low word, plus a 12-bit register offset taken from the request. By convention, window 0 serves as the configuration window.

Top module: `ob_xlate_table`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, every window is disabled and every register reads 0, so any lookup misses.
- R2: Register selects are:
  - 0: control word. Bit 0 is enable, bits 2:1 are type, bits 31:10 are the low part of the mask. Bits 9:3 read 0.
  - 1: upper 32 mask bits.
  - 2: local base low.
  - 3: local base high.
  - 4: bus base low.
  - 5: bus base high.

  Selects 1 to 5 read back all 32 written bits. Selects 6 and 7 read 0.
- R3: When `reg_win` is at or beyond NUM_WIN, `reg_err` is 1, reads return 0 and a write changes no window.
- R4: A window hits when it is enabled and (addr & mask) == (local_base & mask). The mask is {upper word, control bits 31:10, 10 zero bits}.
- R5: For a non-configuration hit, `rsp_addr` = bus_base | (addr & ~mask).
- R6: When several windows hit, the lowest index wins and is reported on `rsp_win`.
- R7: A miss gives `rsp_miss`=1 with `rsp_addr`, `rsp_type` and `rsp_win` all 0.
- R8: `rsp_type` carries the winning window's type code: 0 configuration, 1 I/O, 2 memory, 3 atomic.
- R9: For a configuration-type hit, `rsp_addr` = {32'h0, bus_base_low[31:16], 4'h0, addr[11:0]}. Bus number is bits 31:24, device is bits 23:19, function is bits 18:16.
- R10: A request is accepted when `req_valid` and `req_ready` are both 1. Its result appears on `rsp_valid` after the next clock edge and is held stable while `rsp_ready` is 0. `req_ready` is 1 exactly when no response is pending or `rsp_ready` is 1.
- R11: A disabled window never hits, even when its base and mask match the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_win | input | IDX_W | Window index for register access |
| reg_sel | input | 3 | Register select within the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register (combinational) |
| reg_err | output | 1 | Window index out of range |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_addr | input | 64 | Local request address |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 64 | Translated bus address |
| rsp_type | output | 2 | Transaction type code |
| rsp_miss | output | 1 | No window matched |
| rsp_win | output | $clog2(NUM_WIN) | Index of the winning window |

## Verification
The lookup is tried with several kinds of address:
- An address inside a single 64 KB memory window, which checks the mask and the OR-based translation.
- An address inside two nested windows of different sizes, which shows whether the lowest index takes priority.
- An address that only the larger, higher-index window covers, which shows that the priority does not hide a valid hit.
- Configuration-type addresses with nonzero bits 15:12, which separate the target-ID format from plain translation.
- An atomic window, to check that type code.
- A window that matches but is disabled, then the same window enabled, which shows that enable gates the hit.
- An address that matches nothing, to check the miss output.

Finally, a stall on the response side with a second request queued shows whether the result is held and whether the second request waits.

// File: rtl/ob_xlate_pkg.sv
package ob_xlate_pkg;

  typedef enum logic [1:0] {
    OBT_CFG  = 2'd0,
    OBT_IO   = 2'd1,
    OBT_MEM  = 2'd2,
    OBT_ATOM = 2'd3
  } ob_type_e;

  // one window: enable, type, split inverted size mask, local and bus bases
  typedef struct packed {
    logic        en;
    ob_type_e    typ;
    logic [21:0] mask_lo;   // mask bits 31:10
    logic [31:0] mask_hi;   // mask bits 63:32
    logic [63:0] loc;
    logic [63:0] bus;
  } ob_win_t;

  localparam logic [2:0] SEL_CTRL   = 3'd0;
  localparam logic [2:0] SEL_MASKHI = 3'd1;
  localparam logic [2:0] SEL_LOC_LO = 3'd2;
  localparam logic [2:0] SEL_LOC_HI = 3'd3;
  localparam logic [2:0] SEL_BUS_LO = 3'd4;
  localparam logic [2:0] SEL_BUS_HI = 3'd5;

  function automatic logic [63:0] win_mask(input ob_win_t w);
    return {w.mask_hi, w.mask_lo, 10'b0};
  endfunction

  function automatic logic win_hit(input ob_win_t w, input logic [63:0] a);
    return w.en && ((a & win_mask(w)) == (w.loc & win_mask(w)));
  endfunction

  function automatic logic [63:0] win_xlate(input ob_win_t w, input logic [63:0] a);
    if (w.typ == OBT_CFG)
      return {32'h0, w.bus[31:16], 4'h0, a[11:0]};
    return w.bus | (a & ~win_mask(w));
  endfunction

endpackage

// File: rtl/ob_win_regs.sv
module ob_win_regs
  import ob_xlate_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int IDX_W   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       win_idx,
  input  logic [2:0]             sel,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  output logic                   idx_bad,
  output ob_win_t [NUM_WIN-1:0]  win_q
);

  localparam int WIN_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  assign idx_bad = (32'(win_idx) >= NUM_WIN);

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic wr_this;
    assign wr_this = wr_en && (32'(win_idx) == i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        win_q[i] <= '0;
      end else if (wr_this) begin
        case (sel)
          SEL_CTRL: begin
            win_q[i].en      <= wdata[0];
            win_q[i].typ     <= ob_type_e'(wdata[2:1]);
            win_q[i].mask_lo <= wdata[31:10];
          end
          SEL_MASKHI: win_q[i].mask_hi    <= wdata;
          SEL_LOC_LO: win_q[i].loc[31:0]  <= wdata;
          SEL_LOC_HI: win_q[i].loc[63:32] <= wdata;
          SEL_BUS_LO: win_q[i].bus[31:0]  <= wdata;
          SEL_BUS_HI: win_q[i].bus[63:32] <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    ob_win_t w;
    w = win_q[win_idx[WIN_W-1:0]];
    rdata = '0;
    if (!idx_bad) begin
      case (sel)
        SEL_CTRL:   rdata = {w.mask_lo, 7'b0, w.typ, w.en};
        SEL_MASKHI: rdata = w.mask_hi;
        SEL_LOC_LO: rdata = w.loc[31:0];
        SEL_LOC_HI: rdata = w.loc[63:32];
        SEL_BUS_LO: rdata = w.bus[31:0];
        SEL_BUS_HI: rdata = w.bus[63:32];
        default:    rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/ob_win_match.sv
module ob_win_match
  import ob_xlate_pkg::*;
#(
  parameter int NUM_WIN = 8,
  localparam int WIN_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [63:0]            addr,
  input  ob_win_t [NUM_WIN-1:0]  win_q,
  output logic [NUM_WIN-1:0]     hit_vec,
  output logic [NUM_WIN-1:0]     grant_vec,
  output logic                   any_hit,
  output logic [WIN_W-1:0]       sel_idx
);

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
    assign hit_vec[i] = win_hit(win_q[i], addr);
  end

  // lowest index takes priority
  always_comb begin
    logic taken;
    taken     = 1'b0;
    grant_vec = '0;
    sel_idx   = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (hit_vec[i] && !taken) begin
        grant_vec[i] = 1'b1;
        sel_idx      = WIN_W'(i);
        taken        = 1'b1;
      end
    end
  end

  assign any_hit = |hit_vec;

endmodule

// File: rtl/ob_xlate_table.sv
module ob_xlate_table
  import ob_xlate_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int IDX_W   = 4,
  localparam int WIN_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [IDX_W-1:0]  reg_win,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_err,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [63:0]       rsp_addr,
  output logic [1:0]        rsp_type,
  output logic              rsp_miss,
  output logic [WIN_W-1:0]  rsp_win
);

  ob_win_t [NUM_WIN-1:0] win_q;
  logic [NUM_WIN-1:0]    hit_vec;
  logic [NUM_WIN-1:0]    grant_vec;
  logic                  any_hit;
  logic [WIN_W-1:0]      sel_idx;
  logic                  req_fire;

  ob_win_regs #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .win_idx (reg_win),
    .sel     (reg_sel),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .idx_bad (reg_err),
    .win_q   (win_q)
  );

  ob_win_match #(.NUM_WIN(NUM_WIN)) u_match (
    .addr      (req_addr),
    .win_q     (win_q),
    .hit_vec   (hit_vec),
    .grant_vec (grant_vec),
    .any_hit   (any_hit),
    .sel_idx   (sel_idx)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_type  <= '0;
      rsp_miss  <= 1'b0;
      rsp_win   <= '0;
    end else if (req_fire) begin
      rsp_valid <= 1'b1;
      rsp_miss  <= !any_hit;
      if (any_hit) begin
        rsp_addr <= win_xlate(win_q[sel_idx], req_addr);
        rsp_type <= win_q[sel_idx].typ;
        rsp_win  <= sel_idx;
      end else begin
        rsp_addr <= '0;
        rsp_type <= '0;
        rsp_win  <= '0;
      end
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/ob_xlate_chk.sv
module ob_xlate_chk
  import ob_xlate_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int IDX_W   = 4,
  localparam int WIN_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr_en,
  input logic [IDX_W-1:0]      reg_win,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic [63:0]           rsp_addr,
  input logic [1:0]            rsp_type,
  input logic                  rsp_miss,
  input logic [WIN_W-1:0]      rsp_win,
  input logic [NUM_WIN-1:0]    hit_vec,
  input logic [NUM_WIN-1:0]    grant_vec,
  input ob_win_t [NUM_WIN-1:0] win_q
);

  p_bad_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && (32'(reg_win) >= NUM_WIN)) |=> $stable(win_q));

  p_one_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec) && ((grant_vec != '0) == (hit_vec != '0)));

  p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (rsp_addr == '0 && rsp_type == '0 && rsp_win == '0));

  p_cfg_fmt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_miss && rsp_type == 2'd0) |-> (rsp_addr[63:32] == '0 && rsp_addr[15:12] == '0));

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_type) && $stable(rsp_miss)));

endmodule

bind ob_xlate_table ob_xlate_chk #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .reg_win   (reg_win),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_addr  (rsp_addr),
  .rsp_type  (rsp_type),
  .rsp_miss  (rsp_miss),
  .rsp_win   (rsp_win),
  .hit_vec   (hit_vec),
  .grant_vec (grant_vec),
  .win_q     (win_q)
);

// File: tb/test_ob_xlate_table.sv
module test_ob_xlate_table;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_WIN = 8;
  localparam int IDX_W = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [IDX_W-1:0] reg_win = '0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_err;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_addr;
  logic [1:0]  rsp_type;
  logic        rsp_miss;
  logic [2:0]  rsp_win;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ob_xlate_table #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) i_ob_xlate_table (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_win(reg_win),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_type(rsp_type), .rsp_miss(rsp_miss), .rsp_win(rsp_win)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int win, input int sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_win = IDX_W'(win); reg_sel = 3'(sel); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input int win, input int sel, output logic [31:0] d);
    @(negedge clk);
    reg_win = IDX_W'(win); reg_sel = 3'(sel);
    #1 d = reg_rdata;
  endtask

  // program a window: size is a power of two, at least 1 KB
  task automatic prog(input int win, input int typ, input logic [63:0] loc,
                      input logic [63:0] bus, input logic [63:0] size, input bit en);
    logic [63:0] m;
    m = ~(size - 64'd1);
    wr(win, 1, m[63:32]);
    wr(win, 2, loc[31:0]);
    wr(win, 3, loc[63:32]);
    wr(win, 4, bus[31:0]);
    wr(win, 5, bus[63:32]);
    wr(win, 0, {m[31:10], 7'b0, 2'(typ), en});
  endtask

  task automatic lookup(input logic [63:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [63:0] a, input logic [63:0] ea,
                            input int et, input int ew);
    lookup(a);
    check({req, " valid"}, 64'(rsp_valid), 64'd1);
    check({req, " miss"},  64'(rsp_miss), 64'd0);
    check({req, " addr"},  rsp_addr, ea);
    check({req, " type"},  64'(rsp_type), 64'(et));
    check({req, " win"},   64'(rsp_win), 64'(ew));
  endtask

  task automatic expect_miss(input string req, input logic [63:0] a);
    lookup(a);
    check({req, " valid"}, 64'(rsp_valid), 64'd1);
    check({req, " miss"},  64'(rsp_miss), 64'd1);
    check({req, " addr"},  rsp_addr, 64'd0);
    check({req, " type"},  64'(rsp_type), 64'd0);
  endtask

  function automatic logic [63:0] exp_x(input logic [63:0] bus, input logic [63:0] a,
                                        input logic [63:0] size);
    return bus | (a & (size - 64'd1));
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1 req_ready", 64'(req_ready), 64'd1);
    for (int w = 0; w < NUM_WIN; w++) begin
      rd(w, 0, d);
      check("R1 ctrl zero", 64'(d), 64'd0);
    end
    expect_miss("R1 miss after reset", 64'h1_2000_0000);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(3, 0, 32'hFFFF_FFFF);
    rd(3, 0, d); check("R2 ctrl readback", 64'(d), 64'hFFFF_FC07);
    for (int s = 1; s < 6; s++) begin
      wr(3, s, 32'hA5C3_0000 + 32'(s));
      rd(3, s, d); check("R2 reg readback", 64'(d), 64'hA5C3_0000 + 64'(s));
    end
    rd(3, 6, d); check("R2 unused select", 64'(d), 64'd0);
    wr(3, 0, 32'h0);
    rd(3, 0, d); check("R2 ctrl cleared", 64'(d), 64'd0);
  endtask

  task automatic t_bad_idx();
    logic [31:0] d;
    @(negedge clk);
    reg_win = IDX_W'(NUM_WIN); reg_sel = 3'd0;
    #1 check("R3 reg_err", 64'(reg_err), 64'd1);
    wr(NUM_WIN, 0, 32'hFFFF_FC05);
    wr(NUM_WIN + 3, 0, 32'hFFFF_FC05);
    rd(NUM_WIN, 0, d); check("R3 read zero", 64'(d), 64'd0);
    rd(0, 0, d); check("R3 win0 untouched", 64'(d), 64'd0);
    rd(3, 0, d); check("R3 win3 untouched", 64'(d), 64'd0);
    expect_miss("R3 no window enabled", 64'h0);
  endtask

  task automatic t_translate();
    // window 1: memory, 64 KB; window 2: I/O, 1 MB, overlapping
    prog(1, 2, 64'h1_2000_0000, 64'hAB_0000_0000, 64'h1_0000, 1'b1);
    prog(2, 1, 64'h1_2000_0000, 64'h5000_0000, 64'h10_0000, 1'b1);
    expect_hit("R4 R5 R6 R8 nested lowest", 64'h1_2000_1234,
               exp_x(64'hAB_0000_0000, 64'h1_2000_1234, 64'h1_0000), 2, 1);
    expect_hit("R5 R6 R8 outer only", 64'h1_2008_0010,
               exp_x(64'h5000_0000, 64'h1_2008_0010, 64'h10_0000), 1, 2);
    expect_miss("R4 R7 outside all", 64'h1_2010_0000);
  endtask

  task automatic t_cfg();
    logic [31:0] tgt;
    tgt = (32'd3 << 24) | (32'd5 << 19) | (32'd2 << 16);
    prog(0, 0, 64'h1_0000_0000, {32'h0, tgt}, 64'h1_0000, 1'b1);
    expect_hit("R9 cfg format", 64'h1_0000_7ABC, {32'h0, tgt[31:16], 4'h0, 12'hABC}, 0, 0);
    expect_hit("R9 cfg offset", 64'h1_0000_F004, {32'h0, tgt[31:16], 4'h0, 12'h004}, 0, 0);
  endtask

  task automatic t_atomic_enable();
    prog(4, 3, 64'h7_0000_0000, 64'h9_0000_0000, 64'h400, 1'b1);
    expect_hit("R8 atomic", 64'h7_0000_03FF, 64'h9_0000_03FF, 3, 4);
    prog(5, 2, 64'h8_0000_0000, 64'h2_0000_0000, 64'h1000, 1'b0);
    expect_miss("R11 disabled window", 64'h8_0000_0123);
    wr(5, 0, 32'hFFFF_F005);
    expect_hit("R11 enabled window", 64'h8_0000_0123, 64'h2_0000_0123, 2, 5);
  endtask

  task automatic t_stall();
    logic [63:0] a1, a2;
    a1 = 64'h1_2000_0040;
    a2 = 64'h1_2008_0080;
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = a1;
    @(negedge clk);
    req_addr = a2;
    check("R10 valid after accept", 64'(rsp_valid), 64'd1);
    check("R10 ready low in stall", 64'(req_ready), 64'd0);
    check("R10 first result", rsp_addr, exp_x(64'hAB_0000_0000, a1, 64'h1_0000));
    repeat (2) @(negedge clk);
    check("R10 held valid", 64'(rsp_valid), 64'd1);
    check("R10 held addr", rsp_addr, exp_x(64'hAB_0000_0000, a1, 64'h1_0000));
    check("R10 held win", 64'(rsp_win), 64'd1);
    rsp_ready = 1'b1;
    #1 check("R10 ready follows rsp_ready", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 second result", rsp_addr, exp_x(64'h5000_0000, a2, 64'h10_0000));
    check("R10 second win", 64'(rsp_win), 64'd2);
    @(negedge clk);
    check("R10 drained", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_bad_idx();
    t_translate();
    t_cfg();
    t_atomic_enable();
    t_stall();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule